// File: doc/BRIEF.md
# Accumulator Processor Timing-State Sequencer

This block is a small single-bus accumulator processor whose work is paced by a step counter. The counter walks through up to five timing states, T0 to T4. Every register transfer belongs to exactly one of those states:

- Fetch takes T0 and T1.
- Decode takes T2.
- Execution takes T3 and, for the load instruction, T4.

The processor has these registers:

- an address register, which is the only source of the memory address;
- a program counter;
- a data holding register;
- an accumulator;
- an instruction register;
- a one-bit extend flag;
- the step counter.

The instruction word is 16 bits. The opcode sits in bits 14 to 12, the address field in bits 11 to 0, and bit 15 is not decoded.

The word memory is internal. It is filled through a write port while reset is held, and after that it is only read. Reads are combinational. A word is therefore captured on the same clock edge that ends the state reading it. Three instruction behaviours exist:

- **Load** copies a memory word into the accumulator by way of the data holding register and a pass-through ALU path.
- **Halt** parks the processor in T3.
- **Every other opcode** ends at T3 and changes no data register.

The program counter, accumulator, instruction register, step counter, extend flag and halt indication are brought out as ports. A bench can follow each state and each transfer through them.

Top module: `acc_seq_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets step_o, pc_o, acc_o, instr_o and e_o to 0 and drops halted_o, including when it arrives in the middle of an instruction.
- R2: Without reset, step_o goes 0, 1, 2, 3 on consecutive clocks, moving one state per rising edge.
- R3: pc_o is captured into the address register in T0. The edge that ends T1 loads instr_o with the memory word at that address and raises pc_o by 1 (mod 2^ADDR_W). pc_o is otherwise unchanged.
- R4: For opcode 3'b010 (load), the edge ending T3 captures the memory word addressed by instr bits 11:0 into the data holding register, and step_o becomes 4. During T4, acc_o still shows its old value. The edge ending T4 writes that word unchanged into acc_o and returns step_o to 0, so a load spans 5 clocks.
- R5: Only instruction bits 14:12 are decoded as the opcode, and bit 15 is ignored. Only the low MEM_AW bits of an address select a memory word (8 bits in the default configuration), so address bits 11:8 have no effect there.
- R6: For opcode 3'b111 (halt), step_o stays at 3 and halted_o is high from the start of T3 until reset. While halted, pc_o and acc_o stay unchanged.
- R7: For any opcode other than 3'b010 and 3'b111, step_o returns from 3 to 0 on the next edge (a 4-clock instruction), halted_o stays low and acc_o is unchanged.
- R8: The extend flag e_o is left unchanged by every instruction, so it stays 0 from reset onward.
- R9: A rising edge with pl_we high writes pl_data into the memory word selected by pl_addr. A later load from that address returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 12 | Preload word address |
| pl_data | input | 16 | Preload word |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| instr_o | output | 16 | Instruction register |
| step_o | output | 3 | Current timing state, 0 to 4 |
| e_o | output | 1 | Extend flag |
| halted_o | output | 1 | High while parked in T3 by a halt |

## Verification
The bench runs a program that sweeps opcodes 0 to 6 with bit 15 both clear and set, and with address fields whose upper nibble varies. It checks every timing state of every instruction:

- A design that latched the accumulator a state early, or loaded it straight from memory, would show the new value during T4.
- A design that stepped the program counter outside T1 would miss the expected pc at T0 or T2.
- A design that decoded bit 15, or used more address bits, would run the wrong length or load the wrong word.

The program ends on a halt, which must hold T3 with a frozen pc. The bench then applies a reset mid-instruction and rewrites a data word through the preload port, so a stuck register or a dead write path shows up as a stale value.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int STEP_W = 3;
  localparam int OP_W   = 3;

  typedef enum logic [STEP_W-1:0] {
    ST_T0 = 3'd0,
    ST_T1 = 3'd1,
    ST_T2 = 3'd2,
    ST_T3 = 3'd3,
    ST_T4 = 3'd4
  } step_t;

  localparam logic [OP_W-1:0] OP_LOAD = 3'b010;
  localparam logic [OP_W-1:0] OP_HALT = 3'b111;

  // next timing state: clear wins over hold, hold wins over advance
  function automatic step_t step_advance(input step_t s, input logic clr,
                                         input logic hold);
    step_t n;
    if (clr)       n = ST_T0;
    else if (hold) n = s;
    else begin
      case (s)
        ST_T0:   n = ST_T1;
        ST_T1:   n = ST_T2;
        ST_T2:   n = ST_T3;
        ST_T3:   n = ST_T4;
        default: n = ST_T0;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/acc_seq_step_ctr.sv
module acc_seq_step_ctr
  import acc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_i,
  input  logic  hold_i,
  output step_t step_o
);

  step_t step_q;

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_T0;
    else     step_q <= step_advance(step_q, clr_i, hold_i);
  end

  assign step_o = step_q;

endmodule

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] words [DEPTH];
  logic [MEM_AW-1:0] widx;
  logic [MEM_AW-1:0] ridx;

  generate
    if (MEM_AW < ADDR_W) begin : g_alias
      logic [ADDR_W-MEM_AW-1:0] unused_whi;
      logic [ADDR_W-MEM_AW-1:0] unused_rhi;
      assign widx       = waddr_i[MEM_AW-1:0];
      assign ridx       = raddr_i[MEM_AW-1:0];
      assign unused_whi = waddr_i[ADDR_W-1:MEM_AW];
      assign unused_rhi = raddr_i[ADDR_W-1:MEM_AW];
    end else begin : g_full
      assign widx = waddr_i;
      assign ridx = raddr_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we_i) words[widx] <= wdata_i;
  end

  assign rdata_o = words[ridx];

endmodule

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
(
  input  step_t           step_i,
  input  logic [OP_W-1:0] op_i,
  output logic            is_load_o,
  output logic            is_halt_o,
  output logic            is_other_o,
  output logic            seq_clr_o,
  output logic            seq_hold_o
);

  always_comb begin
    is_load_o  = (op_i == OP_LOAD);
    is_halt_o  = (op_i == OP_HALT);
    is_other_o = !is_load_o && !is_halt_o;
  end

  always_comb begin
    seq_clr_o  = 1'b0;
    seq_hold_o = 1'b0;
    case (step_i)
      ST_T3: begin
        seq_clr_o  = is_other_o;
        seq_hold_o = is_halt_o;
      end
      ST_T4:   seq_clr_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_t0_i,
  input  logic              ev_t1_i,
  input  logic              ev_t2_i,
  input  logic              ld_cap_i,
  input  logic              acc_wr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] instr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              e_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] instr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] acc_q;
  logic              e_q;

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  // pass-through ALU path: the load moves data untouched, flag untouched
  function automatic logic [DATA_W:0] alu_pass(input logic [DATA_W-1:0] d,
                                               input logic e);
    return {e, d};
  endfunction

  logic [DATA_W:0] alu_out;
  assign alu_out = alu_pass(data_q, e_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      pc_q    <= '0;
      instr_q <= '0;
      data_q  <= '0;
      acc_q   <= '0;
      e_q     <= 1'b0;
    end else begin
      if (ev_t0_i) addr_q <= pc_q;
      if (ev_t1_i) begin
        instr_q <= mem_rdata_i;
        pc_q    <= pc_step(pc_q);
      end
      if (ev_t2_i)  addr_q <= instr_q[ADDR_W-1:0];
      if (ld_cap_i) data_q <= mem_rdata_i;
      if (acc_wr_i) begin
        acc_q <= alu_out[DATA_W-1:0];
        e_q   <= alu_out[DATA_W];
      end
    end
  end

  assign addr_o  = addr_q;
  assign pc_o    = pc_q;
  assign instr_o = instr_q;
  assign acc_o   = acc_q;
  assign e_o     = e_q;

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] instr_o,
  output logic [STEP_W-1:0] step_o,
  output logic              e_o,
  output logic              halted_o
);

  localparam int OP_LSB = ADDR_W;

  step_t             step_w;
  logic [OP_W-1:0]   op_w;
  logic              is_load_w;
  logic              is_halt_w;
  logic              is_other_w;
  logic              seq_clr_w;
  logic              seq_hold_w;
  logic              ev_t0_w;
  logic              ev_t1_w;
  logic              ev_t2_w;
  logic              ld_cap_w;
  logic              acc_wr_w;
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] rdata_w;
  logic [DATA_W-1:0] instr_w;

  assign op_w     = instr_w[OP_LSB +: OP_W];
  assign ev_t0_w  = (step_w == ST_T0);
  assign ev_t1_w  = (step_w == ST_T1);
  assign ev_t2_w  = (step_w == ST_T2);
  assign ld_cap_w = (step_w == ST_T3) && is_load_w;
  assign acc_wr_w = (step_w == ST_T4) && is_load_w;

  acc_seq_step_ctr u_step (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (seq_clr_w),
    .hold_i (seq_hold_w),
    .step_o (step_w)
  );

  acc_seq_decode u_dec (
    .step_i     (step_w),
    .op_i       (op_w),
    .is_load_o  (is_load_w),
    .is_halt_o  (is_halt_w),
    .is_other_o (is_other_w),
    .seq_clr_o  (seq_clr_w),
    .seq_hold_o (seq_hold_w)
  );

  acc_seq_mem #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW)
  ) u_mem (
    .clk     (clk),
    .we_i    (pl_we),
    .waddr_i (pl_addr),
    .wdata_i (pl_data),
    .raddr_i (addr_w),
    .rdata_o (rdata_w)
  );

  acc_seq_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ev_t0_i     (ev_t0_w),
    .ev_t1_i     (ev_t1_w),
    .ev_t2_i     (ev_t2_w),
    .ld_cap_i    (ld_cap_w),
    .acc_wr_i    (acc_wr_w),
    .mem_rdata_i (rdata_w),
    .addr_o      (addr_w),
    .pc_o        (pc_o),
    .instr_o     (instr_w),
    .acc_o       (acc_o),
    .e_o         (e_o)
  );

  assign instr_o  = instr_w;
  assign step_o   = step_w;
  assign halted_o = (step_w == ST_T3) && is_halt_w;

endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        step,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic              e,
  input logic              halted,
  input logic              is_load,
  input logic              is_other
);

  assert_step_adv_R2: assert property (@(posedge clk) disable iff (rst)
    (step < 3'd3) |=> (step == $past(step) + 3'd1));

  assert_step_range_R2: assert property (@(posedge clk) disable iff (rst)
    (step <= 3'd4));

  assert_pc_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd1) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (step != 3'd1) |=> $stable(pc));

  assert_acc_only_t4_R4: assert property (@(posedge clk) disable iff (rst)
    (step != 3'd4) |=> $stable(acc));

  assert_load_t4_R4: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd3 && is_load) |=> (step == 3'd4));

  assert_t4_return_R4: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd4) |=> (step == 3'd0));

  assert_halt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && step == 3'd3));

  assert_other_return_R7: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd3 && is_other) |=> (step == 3'd0 && !halted));

  assert_e_stable_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(e));

endmodule

bind acc_seq_core acc_seq_core_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step     (step_w),
  .pc       (pc_o),
  .acc      (acc_o),
  .e        (e_o),
  .halted   (halted_o),
  .is_load  (is_load_w),
  .is_other (is_other_w)
);

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int MEM_AW = 8;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int NPROG  = 126;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pl_we = 1'b0;
  logic [ADDR_W-1:0] pl_addr = '0;
  logic [DATA_W-1:0] pl_data = '0;
  logic [ADDR_W-1:0] pc_o;
  logic [DATA_W-1:0] acc_o;
  logic [DATA_W-1:0] instr_o;
  logic [2:0]        step_o;
  logic              e_o;
  logic              halted_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [DATA_W-1:0] mem_m [DEPTH];
  logic [DATA_W-1:0] exp_acc;
  logic [ADDR_W-1:0] ipc;
  bit                pass2;

  always #5 clk = ~clk;

  acc_seq_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .pc_o(pc_o), .acc_o(acc_o), .instr_o(instr_o), .step_o(step_o),
    .e_o(e_o), .halted_o(halted_o)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic preload(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    pl_we   = 1'b1;
    pl_addr = ADDR_W'(a);
    pl_data = d;
    @(negedge clk);
    pl_we   = 1'b0;
  endtask

  task automatic chk_reset_state();
    chk("R1 step after reset", step_o, 0);
    chk("R1 pc after reset", pc_o, 0);
    chk("R1 acc after reset", acc_o, 0);
    chk("R1 instr after reset", instr_o, 0);
    chk("R1 e after reset", e_o, 0);
    chk("R1 halted after reset", halted_o, 0);
  endtask

  // entered just after a falling edge with the design in T0
  task automatic run_instr(input int idx, output bit hit_halt);
    logic [DATA_W-1:0] w;
    logic [2:0]        op;
    w  = mem_m[idx];
    op = w[14:12];
    hit_halt = 0;
    chk("R2 R4 R7 step at T0", step_o, 0);
    chk("R3 pc at T0", pc_o, ipc);
    chk("R4 R7 acc at T0", acc_o, exp_acc);
    chk("R8 e flag", e_o, 0);
    @(negedge clk);
    chk("R2 step T1", step_o, 1);
    chk("R3 pc held in T1", pc_o, ipc);
    @(negedge clk);
    chk("R2 step T2", step_o, 2);
    chk("R3 instr fetched", instr_o, w);
    chk("R3 pc incremented", pc_o, ADDR_W'(ipc + 1));
    @(negedge clk);
    chk("R2 step T3", step_o, 3);
    if (op == 3'b111) begin
      chk("R6 halted at T3", halted_o, 1);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk("R6 step held", step_o, 3);
        chk("R6 halted held", halted_o, 1);
        chk("R6 pc frozen", pc_o, ADDR_W'(ipc + 1));
        chk("R6 acc frozen", acc_o, exp_acc);
      end
      hit_halt = 1;
      return;
    end
    chk("R7 R4 halted low", halted_o, 0);
    if (op == 3'b010) begin
      @(negedge clk);
      chk("R4 step T4", step_o, 4);
      chk("R4 acc old in T4", acc_o, exp_acc);
      exp_acc = mem_m[w[MEM_AW-1:0]];
      @(negedge clk);
      if (pass2)
        chk("R9 load of rewritten word", acc_o, exp_acc);
      else if (w[15] || w[11:8] != 4'd0)
        chk("R5 load ignoring bit15/high addr", acc_o, exp_acc);
      else
        chk("R4 load value", acc_o, exp_acc);
    end else begin
      @(negedge clk);
      if (w[15]) chk("R5 bit15 other-op length", step_o, 0);
    end
    ipc = ADDR_W'(ipc + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    bit h;
    int w2;
    rst   = 1'b1;
    pass2 = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < NPROG) begin
        logic [2:0]        op;
        logic              b15;
        logic [ADDR_W-1:0] a;
        op  = 3'(i % 7);
        b15 = ((i / 7) % 2) == 1;
        a   = ADDR_W'((i * 419) & 12'hFFF) | 12'h080;
        mem_m[i] = {b15, op, a};
      end else if (i == NPROG) begin
        mem_m[i] = {1'b0, 3'b111, 12'h000};
      end else begin
        mem_m[i] = DATA_W'(i * 16'h9E37) ^ 16'h5A5A;
      end
    end
    for (int i = 0; i < DEPTH; i++) preload(i, mem_m[i]);
    @(negedge clk);
    chk_reset_state();
    exp_acc = '0;
    ipc     = '0;
    rst     = 1'b0;
    for (int i = 0; i <= NPROG; i++) begin
      run_instr(i, h);
      if (h) break;
    end
    chk("R6 program reached halt", h, 1);

    // reset while halted, rewrite the word loaded by instruction 2
    rst = 1'b1;
    @(negedge clk);
    chk_reset_state();
    w2 = int'(mem_m[2][MEM_AW-1:0]);
    mem_m[w2] = 16'hBEEF;
    preload(w2, 16'hBEEF);
    exp_acc = '0;
    ipc     = '0;
    pass2   = 1;
    rst     = 1'b0;
    for (int i = 0; i < 3; i++) run_instr(i, h);

    // reset in the middle of the next instruction (T2)
    @(negedge clk);
    @(negedge clk);
    chk("R2 step before mid reset", step_o, 2);
    rst = 1'b1;
    @(negedge clk);
    chk_reset_state();
    rst = 1'b0;
    @(negedge clk);
    chk("R2 step after restart", step_o, 1);
    summary();
  end

endmodule